// File: doc/BRIEF.md
# Dual-Port Byte-Lane Memory

This block is a synchronous, true dual-port word memory. Two ports, called left and right, each have their own address, write data, write strobe, output enable, two byte-lane enables and a pair of chip selects of opposite polarity. Each port works on its own and can reach any word in the same cycle as the other port, including the same word. Reads are registered. The data and a per-lane valid flag appear at the clock edge that samples the request. A lane that is not driven reads as zero with its valid flag low. This stands in for a released bus.

Same-address write conflicts are resolved by a strap input. With the strap set to master, the left port wins a same-word write and the block raises a busy flag toward the right port for that cycle. With the strap set to slave, each port has a busy input that blocks its writes, and this lets a master instance elsewhere arbitrate a wider, cascaded memory. The word count is 2^ADDR_W. Setting ADDR_W to 15 gives the full 32768 x 16 array. The default is kept small.

Top module: `dpr_top`

## Requirements
- R1: A word written on either port with both lanes enabled is returned unchanged by a later full-word read of that address from either port. The memory holds 2^ADDR_W words of 16 bits.
- R2: A port is selected only when its `cs_n` is 0 and its `cs` is 1. Every other combination causes no write on that port, and at the next edge that port's `rvld` is 00 and its `rdata` is 0.
- R3: On a write (`we`=1, port selected), `be[1]` enables bits 15:8 and `be[0]` enables bits 7:0. Lanes whose enable is 0 keep their stored value, so `be`=00 changes nothing.
- R4: A read (`we`=0, `oe`=1, port selected) sets `rvld` equal to `be` at the next clock edge. It places the stored byte on each valid lane and zero on each other lane.
- R5: With `oe`=0, or during a write, both `rvld` bits are 0 and `rdata` is 0 after the edge, whatever the other controls are.
- R6: Both ports can read or write at the same time, including at the same address, each according to its own controls.
- R7: With `is_master`=1, when both selected ports write at the same address with at least one lane each, the right port's write is dropped entirely and `r_busy_out` is 1 in that same cycle. `l_busy_out` stays 0 and both busy inputs are ignored.
- R8: With `is_master`=0, a port whose `busy_in` is 1 writes nothing, and both busy outputs stay 0.
- R9: A read of a word that the other port writes in the same cycle returns the data stored before that write.
- R10: With `is_master`=0 and neither port blocked, if both ports write the same lane of the same word in one cycle, the left port's byte is stored.
- R11: While `rst_n` is 0 at a clock edge, both ports' `rvld` and `rdata` become 0. Stored words are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| is_master | input | 1 | Strap: 1 = master (busy is an output), 0 = slave (busy is an input) |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 16 | Left write data |
| l_we | input | 1 | Left write strobe (1 = write, 0 = read) |
| l_oe | input | 1 | Left output enable |
| l_be | input | 2 | Left lane enables, bit 1 upper byte, bit 0 lower byte |
| l_cs_n | input | 1 | Left active-low chip select |
| l_cs | input | 1 | Left active-high chip select |
| l_busy_in | input | 1 | Left write block, used in slave mode |
| l_rdata | output | 16 | Left read data, zero on lanes that are not valid |
| l_rvld | output | 2 | Left per-lane valid flags |
| l_busy_out | output | 1 | Left busy flag, always 0 |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 16 | Right write data |
| r_we | input | 1 | Right write strobe |
| r_oe | input | 1 | Right output enable |
| r_be | input | 2 | Right lane enables, bit 1 upper byte, bit 0 lower byte |
| r_cs_n | input | 1 | Right active-low chip select |
| r_cs | input | 1 | Right active-high chip select |
| r_busy_in | input | 1 | Right write block, used in slave mode |
| r_rdata | output | 16 | Right read data |
| r_rvld | output | 2 | Right per-lane valid flags |
| r_busy_out | output | 1 | Right busy flag, master same-address write collision |

## Verification
The assertions assume the strap `is_master` is steady while out of reset. They also assume every control input is a defined level at each sampled edge, so select decoding and the address compare never see unknowns. The stimulus changes inputs only on the falling clock edge and flips the strap only between separate phases. Each phase, random ones included, draws from defined values only and keeps addresses to a small window so that same-address collisions happen often.

// File: rtl/dpr_pkg.sv
// Package: shared lane geometry and the decoded per-port command.
// Assumes a 16-bit word split into two byte lanes.
package dpr_pkg;
    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef struct packed {
        logic             sel;      // port selected
        logic [LANES-1:0] wr_lane;  // lanes written this cycle
        logic [LANES-1:0] rd_lane;  // lanes driven on the next read result
    } port_cmd_t;
endpackage

// File: rtl/dpr_port_decode.sv
// Port decoder: turns chip selects, write strobe, output enable and lane
// enables into a command. Assumes all inputs are already synchronous.
module dpr_port_decode
    import dpr_pkg::*;
(
    input  logic             cs_n,
    input  logic             cs,
    input  logic             we,
    input  logic             oe,
    input  logic [LANES-1:0] be,
    output port_cmd_t        cmd
);
    // Decode the select pair and the access type into lane masks.
    always_comb begin
        cmd.sel     = ~cs_n & cs;
        cmd.wr_lane = (cmd.sel & we) ? be : '0;
        cmd.rd_lane = (cmd.sel & ~we & oe) ? be : '0;
    end
endmodule

// File: rtl/dpr_collide.sv
// Write-collision filter: master mode drops the right write on a
// same-address write and flags busy; slave mode blocks writes by busy input.
// Assumes is_master is a static strap.
module dpr_collide
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              is_master,
    input  port_cmd_t         cmd_l,
    input  port_cmd_t         cmd_r,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic              busy_in_l,
    input  logic              busy_in_r,
    output logic [LANES-1:0]  wen_l,
    output logic [LANES-1:0]  wen_r,
    output logic              busy_out_l,
    output logic              busy_out_r
);
    logic hit;

    // Detect a same-word write by both ports.
    always_comb hit = (|cmd_l.wr_lane) & (|cmd_r.wr_lane) & (addr_l == addr_r);

    // Gate the write lanes and drive the busy flags per strap mode.
    always_comb begin
        busy_out_l = 1'b0;
        if (is_master) begin
            busy_out_r = hit;
            wen_l      = cmd_l.wr_lane;
            wen_r      = hit ? '0 : cmd_r.wr_lane;
        end else begin
            busy_out_r = 1'b0;
            wen_l      = busy_in_l ? '0 : cmd_l.wr_lane;
            wen_r      = busy_in_r ? '0 : cmd_r.wr_lane;
        end
    end
endmodule

// File: rtl/dpr_bank.sv
// Storage bank: one byte array per lane with two write and two registered
// read ports. Left has priority on a same-lane same-word write; reads see
// the contents from before the edge. Storage is not reset.
module dpr_bank
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic [WORD_W-1:0] wdata_l,
    input  logic [WORD_W-1:0] wdata_r,
    input  logic [LANES-1:0]  wen_l,
    input  logic [LANES-1:0]  wen_r,
    input  logic [LANES-1:0]  ren_l,
    input  logic [LANES-1:0]  ren_r,
    output logic [WORD_W-1:0] rdata_l,
    output logic [WORD_W-1:0] rdata_r,
    output logic [LANES-1:0]  rvld_l,
    output logic [LANES-1:0]  rvld_r
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] q_l, q_r;
        logic              v_l, v_r;

        // Lane writes: right first so a left write to the same byte wins.
        always_ff @(posedge clk) begin
            if (wen_r[g]) mem[addr_r] <= wdata_r[g*LANE_W +: LANE_W];
            if (wen_l[g]) mem[addr_l] <= wdata_l[g*LANE_W +: LANE_W];
        end

        // Registered lane reads with zero fill when the lane is not driven.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_l <= '0; q_r <= '0; v_l <= 1'b0; v_r <= 1'b0;
            end else begin
                v_l <= ren_l[g];
                v_r <= ren_r[g];
                q_l <= ren_l[g] ? mem[addr_l] : '0;
                q_r <= ren_r[g] ? mem[addr_r] : '0;
            end
        end

        assign rdata_l[g*LANE_W +: LANE_W] = q_l;
        assign rdata_r[g*LANE_W +: LANE_W] = q_r;
        assign rvld_l[g] = v_l;
        assign rvld_r[g] = v_r;
    end
endmodule

// File: rtl/dpr_top.sv
// Dual-port byte-lane memory top: two decoders, the collision filter and
// the storage bank. Assumes one clock for both ports and a static strap.
module dpr_top
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_master,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [15:0]       l_wdata,
    input  logic              l_we,
    input  logic              l_oe,
    input  logic [1:0]        l_be,
    input  logic              l_cs_n,
    input  logic              l_cs,
    input  logic              l_busy_in,
    output logic [15:0]       l_rdata,
    output logic [1:0]        l_rvld,
    output logic              l_busy_out,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [15:0]       r_wdata,
    input  logic              r_we,
    input  logic              r_oe,
    input  logic [1:0]        r_be,
    input  logic              r_cs_n,
    input  logic              r_cs,
    input  logic              r_busy_in,
    output logic [15:0]       r_rdata,
    output logic [1:0]        r_rvld,
    output logic              r_busy_out
);
    port_cmd_t        cmd_l, cmd_r;
    logic [LANES-1:0] wen_l, wen_r;

    dpr_port_decode u_dec_l (
        .cs_n(l_cs_n), .cs(l_cs), .we(l_we), .oe(l_oe), .be(l_be), .cmd(cmd_l)
    );
    dpr_port_decode u_dec_r (
        .cs_n(r_cs_n), .cs(r_cs), .we(r_we), .oe(r_oe), .be(r_be), .cmd(cmd_r)
    );

    dpr_collide #(.ADDR_W(ADDR_W)) u_col (
        .is_master (is_master),
        .cmd_l     (cmd_l),
        .cmd_r     (cmd_r),
        .addr_l    (l_addr),
        .addr_r    (r_addr),
        .busy_in_l (l_busy_in),
        .busy_in_r (r_busy_in),
        .wen_l     (wen_l),
        .wen_r     (wen_r),
        .busy_out_l(l_busy_out),
        .busy_out_r(r_busy_out)
    );

    dpr_bank #(.ADDR_W(ADDR_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr_l (l_addr),
        .addr_r (r_addr),
        .wdata_l(l_wdata),
        .wdata_r(r_wdata),
        .wen_l  (wen_l),
        .wen_r  (wen_r),
        .ren_l  (cmd_l.rd_lane),
        .ren_r  (cmd_r.rd_lane),
        .rdata_l(l_rdata),
        .rdata_r(r_rdata),
        .rvld_l (l_rvld),
        .rvld_r (r_rvld)
    );
endmodule

// File: rtl/dpr_checker.sv
// Checker: port-level properties of the dual-port memory, bound to dpr_top.
// Assumes is_master is steady while out of reset.
module dpr_checker #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              is_master,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_we,
    input logic              l_oe,
    input logic [1:0]        l_be,
    input logic              l_cs_n,
    input logic              l_cs,
    input logic [15:0]       l_rdata,
    input logic [1:0]        l_rvld,
    input logic              l_busy_out,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_we,
    input logic              r_oe,
    input logic [1:0]        r_be,
    input logic              r_cs_n,
    input logic              r_cs,
    input logic [15:0]       r_rdata,
    input logic [1:0]        r_rvld,
    input logic              r_busy_out
);
    a_r2_left_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_cs_n && l_cs) |=> (l_rvld == 2'b00));
    a_r2_right_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        !(!r_cs_n && r_cs) |=> (r_rvld == 2'b00));
    a_r4_left_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_cs_n && l_cs && !l_we && l_oe) |=> (l_rvld == $past(l_be)));
    a_r4_right_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_cs_n && r_cs && !r_we && r_oe) |=> (r_rvld == $past(r_be)));
    a_r4_left_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        ((l_rvld[1] || l_rdata[15:8] == 8'h00) && (l_rvld[0] || l_rdata[7:0] == 8'h00)));
    a_r4_right_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_rvld[1] || r_rdata[15:8] == 8'h00) && (r_rvld[0] || r_rdata[7:0] == 8'h00)));
    a_r5_left_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_oe || l_we) |=> (l_rvld == 2'b00));
    a_r5_right_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_oe || r_we) |=> (r_rvld == 2'b00));
    a_r7_master_collision: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && !l_cs_n && l_cs && l_we && (|l_be) && !r_cs_n && r_cs && r_we
         && (|r_be) && l_addr == r_addr) |-> r_busy_out);
    a_r7_left_never_busy: assert property (@(posedge clk) disable iff (!rst_n)
        is_master |-> !l_busy_out);
    a_r8_slave_outputs_low: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> !(l_busy_out || r_busy_out));
endmodule

bind dpr_top dpr_checker #(.ADDR_W(ADDR_W)) u_dpr_checker (
    .clk(clk), .rst_n(rst_n), .is_master(is_master),
    .l_addr(l_addr), .l_we(l_we), .l_oe(l_oe), .l_be(l_be), .l_cs_n(l_cs_n),
    .l_cs(l_cs), .l_rdata(l_rdata), .l_rvld(l_rvld), .l_busy_out(l_busy_out),
    .r_addr(r_addr), .r_we(r_we), .r_oe(r_oe), .r_be(r_be), .r_cs_n(r_cs_n),
    .r_cs(r_cs), .r_rdata(r_rdata), .r_rvld(r_rvld), .r_busy_out(r_busy_out)
);

// File: tb/tb_dpr_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model of both ports, compared every clock.
module tb_dpr_top;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic is_master = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [15:0] l_wdata = '0, r_wdata = '0;
    logic l_we = 1'b0, r_we = 1'b0, l_oe = 1'b0, r_oe = 1'b0;
    logic [1:0] l_be = 2'b00, r_be = 2'b00;
    logic l_cs_n = 1'b1, r_cs_n = 1'b1, l_cs = 1'b0, r_cs = 1'b0;
    logic l_busy_in = 1'b0, r_busy_in = 1'b0;
    logic [15:0] l_rdata, r_rdata;
    logic [1:0] l_rvld, r_rvld;
    logic l_busy_out, r_busy_out;

    int n_checks = 0;
    int n_errors = 0;
    logic [15:0] model [DEPTH];

    always #4 clk = ~clk;

    dpr_top #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .is_master(is_master),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_we(l_we), .l_oe(l_oe), .l_be(l_be),
        .l_cs_n(l_cs_n), .l_cs(l_cs), .l_busy_in(l_busy_in),
        .l_rdata(l_rdata), .l_rvld(l_rvld), .l_busy_out(l_busy_out),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_we(r_we), .r_oe(r_oe), .r_be(r_be),
        .r_cs_n(r_cs_n), .r_cs(r_cs), .r_busy_in(r_busy_in),
        .r_rdata(r_rdata), .r_rvld(r_rvld), .r_busy_out(r_busy_out)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    // One clock: inputs already driven; predict busy, outputs, then update model.
    task automatic step(input string tag);
        logic sl, sr, hit;
        logic [1:0] wl, wr, rl, rr;
        logic [15:0] el, er;
        logic ebr;
        #1;
        sl = !l_cs_n && l_cs;
        sr = !r_cs_n && r_cs;
        wl = (sl && l_we) ? l_be : 2'b00;
        wr = (sr && r_we) ? r_be : 2'b00;
        rl = (sl && !l_we && l_oe) ? l_be : 2'b00;
        rr = (sr && !r_we && r_oe) ? r_be : 2'b00;
        ebr = 1'b0;
        if (is_master) begin
            hit = (wl != 0) && (wr != 0) && (l_addr == r_addr);
            ebr = hit;
            if (hit) wr = 2'b00;
        end else begin
            if (l_busy_in) wl = 2'b00;
            if (r_busy_in) wr = 2'b00;
        end
        if (!rst_n) begin rl = 2'b00; rr = 2'b00; end
        el = model[l_addr] & lane_mask(rl);
        er = model[r_addr] & lane_mask(rr);
        if (rst_n) begin
            check(l_busy_out == 1'b0, tag, "l_busy_out", 32'(l_busy_out), 32'd0);
            check(r_busy_out == ebr, tag, "r_busy_out", 32'(r_busy_out), 32'(ebr));
        end
        model[r_addr] = (model[r_addr] & ~lane_mask(wr)) | (r_wdata & lane_mask(wr));
        model[l_addr] = (model[l_addr] & ~lane_mask(wl)) | (l_wdata & lane_mask(wl));
        @(posedge clk);
        #1;
        check(l_rvld == rl, tag, "l_rvld", 32'(l_rvld), 32'(rl));
        check(r_rvld == rr, tag, "r_rvld", 32'(r_rvld), 32'(rr));
        check(l_rdata == el, tag, "l_rdata", 32'(l_rdata), 32'(el));
        check(r_rdata == er, tag, "r_rdata", 32'(r_rdata), 32'(er));
        @(negedge clk);
    endtask

    task automatic idle();
        l_cs_n = 1'b1; l_cs = 1'b0; r_cs_n = 1'b1; r_cs = 1'b0;
        l_we = 1'b0; r_we = 1'b0; l_oe = 1'b0; r_oe = 1'b0;
        l_be = 2'b00; r_be = 2'b00; l_busy_in = 1'b0; r_busy_in = 1'b0;
    endtask

    task automatic lset(input logic [AW-1:0] a, input logic we, input logic oe,
                        input logic [1:0] be, input logic [15:0] d);
        l_cs_n = 1'b0; l_cs = 1'b1; l_addr = a; l_we = we; l_oe = oe; l_be = be; l_wdata = d;
    endtask

    task automatic rset(input logic [AW-1:0] a, input logic we, input logic oe,
                        input logic [1:0] be, input logic [15:0] d);
        r_cs_n = 1'b0; r_cs = 1'b1; r_addr = a; r_we = we; r_oe = oe; r_be = be; r_wdata = d;
    endtask

    initial begin
        #(8 * 20000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        @(negedge clk);
        // R11: outputs cleared while reset is held, even with a read requested.
        idle(); lset(0, 0, 1, 2'b11, 0);
        step("R11"); step("R11");
        rst_n = 1'b1;
        idle();
        // R1: fill the whole array from the left, read back from the right.
        for (int i = 0; i < DEPTH; i++) begin
            idle(); lset(AW'(i), 1, 1, 2'b11, 16'(16'hA500 ^ (i * 16'h0103))); step("R1");
        end
        for (int i = 0; i < DEPTH; i++) begin
            idle(); rset(AW'(i), 0, 1, 2'b11, 0); step("R1");
        end
        // R3: upper only, lower only, no lane.
        idle(); lset(3, 1, 0, 2'b10, 16'h1234); step("R3");
        idle(); lset(4, 1, 0, 2'b01, 16'h5678); step("R3");
        idle(); lset(5, 1, 0, 2'b00, 16'h9ABC); step("R3");
        for (int i = 3; i < 6; i++) begin idle(); lset(AW'(i), 0, 1, 2'b11, 0); step("R3"); end
        // R4: partial-lane reads.
        idle(); lset(7, 0, 1, 2'b10, 0); rset(8, 0, 1, 2'b01, 0); step("R4");
        idle(); lset(7, 0, 1, 2'b00, 0); rset(8, 0, 1, 2'b11, 0); step("R4");
        // R5: output enable off, and write cycles, give no valid lanes.
        idle(); lset(9, 0, 0, 2'b11, 0); rset(9, 0, 0, 2'b11, 0); step("R5");
        idle(); lset(10, 1, 1, 2'b11, 16'hBEEF); step("R5");
        // R2: each non-selecting chip-select combination blocks write and read.
        idle(); lset(11, 1, 1, 2'b11, 16'hDEAD); l_cs_n = 1'b1; l_cs = 1'b1; step("R2");
        idle(); lset(11, 1, 1, 2'b11, 16'hDEAD); l_cs_n = 1'b0; l_cs = 1'b0; step("R2");
        idle(); lset(11, 1, 1, 2'b11, 16'hDEAD); l_cs_n = 1'b1; l_cs = 1'b0; step("R2");
        idle(); rset(11, 0, 1, 2'b11, 0); r_cs_n = 1'b1; r_cs = 1'b1; step("R2");
        idle(); rset(11, 0, 1, 2'b11, 0); step("R2");
        // R6: both ports read the same word together.
        idle(); lset(12, 0, 1, 2'b11, 0); rset(12, 0, 1, 2'b11, 0); step("R6");
        // R7: master collision, busy inputs high but ignored.
        idle(); l_busy_in = 1'b1; r_busy_in = 1'b1;
        lset(13, 1, 0, 2'b01, 16'h1111); rset(13, 1, 0, 2'b10, 16'h2222); step("R7");
        idle(); lset(13, 0, 1, 2'b11, 0); step("R7");
        idle(); lset(14, 1, 0, 2'b11, 16'h3333); rset(15, 1, 0, 2'b11, 16'h4444); step("R7");
        // R9: read sees old data while the other port writes it.
        idle(); lset(16, 1, 0, 2'b11, 16'hCAFE); rset(16, 0, 1, 2'b11, 0); step("R9");
        idle(); rset(16, 0, 1, 2'b11, 0); step("R9");
        // R8: slave mode, busy input blocks writes.
        is_master = 1'b0;
        idle(); r_busy_in = 1'b1; rset(17, 1, 0, 2'b11, 16'h7777); step("R8");
        idle(); l_busy_in = 1'b1; lset(18, 1, 0, 2'b11, 16'h8888); step("R8");
        idle(); lset(17, 0, 1, 2'b11, 0); rset(18, 0, 1, 2'b11, 0); step("R8");
        // R10: slave same-lane write, left byte kept.
        idle(); lset(19, 1, 0, 2'b11, 16'hAAAA); rset(19, 1, 0, 2'b01, 16'h5555); step("R10");
        idle(); lset(19, 0, 1, 2'b11, 0); step("R10");
        // R6: random traffic in both modes over a narrow address window.
        for (int m = 0; m < 2; m++) begin
            is_master = (m == 0);
            for (int k = 0; k < 400; k++) begin
                logic [31:0] a, b;
                a = $urandom; b = $urandom;
                l_cs_n = (a[3:0] == 0); l_cs = (a[7:4] != 0);
                r_cs_n = (b[3:0] == 0); r_cs = (b[7:4] != 0);
                l_we = a[8]; r_we = b[8]; l_oe = a[9] | a[10]; r_oe = b[9] | b[10];
                l_be = a[12:11]; r_be = b[12:11];
                l_addr = AW'(a[14:13]); r_addr = AW'(b[14:13]);
                l_busy_in = a[15] & a[16]; r_busy_in = b[15] & b[16];
                l_wdata = a[31:16]; r_wdata = b[31:16];
                step("R6");
            end
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule